// File: doc/BRIEF.md
# Multi-Mode ADC Scan Sequencer

This block sequences an external two-channel ADC from the always-on clock domain. It drives the converter's power-down line, a channel select and a one-cycle start strobe. It receives back a data-valid strobe with a 10-bit result. Each round converts channel 0 and then channel 1. The latest result of each channel is kept in a register. An external filter block looks at those results and returns one match flag per round.

There are three operating modes, selected by `mode_i`. In low-power scan the ADC is woken once per programmable interval for one round and then powered down again. After a programmable number of consecutive matching rounds, the block promotes itself to normal-power scan. In normal-power scan the rounds run back to back with the ADC kept powered. A second programmable count of consecutive matches fires a one-cycle trigger, and the sample values of that round are frozen as the triggering values. In oneshot mode exactly one round is taken, a done pulse is raised, and the ADC is powered down until enable is toggled or a soft reset is applied.

Top module: `adc_scan_sequencer`

## Requirements
- R1: While reset is held and just after it: `adc_pd_o`=1, `adc_start_o`=0, `np_active_o`=0, `trigger_o`=0, `oneshot_done_o`=0, and all stored sample values are 0.
- R2: After enable rises from idle, `adc_pd_o` is low for exactly `pwrup_time_i`+1 cycles before the first `adc_start_o` pulse.
- R3: A round converts channel 0 first (`adc_chn_sel_o`=0), then channel 1 (`adc_chn_sel_o`=1). Each start is a one-cycle pulse with `adc_pd_o` low. The result returned with `adc_valid_i` is stored as that channel's latest value on `latest_o` (channel c at bits [10c+9:10c]).
- R4: In low-power scan (`mode_i`=0), a round that does not promote is followed by `adc_pd_o` high for exactly `wake_time_i`+1 cycles, and then a new power-up.
- R5: In low-power scan, `np_active_o` rises after `lp_thresh_i` consecutive rounds that end with `match_i` high while `filter_en_i`=1, and the ADC stays powered. With `filter_en_i`=0 it never rises.
- R6: In normal-power scan (`mode_i`=1, or after promotion), `adc_pd_o` stays low between rounds.
- R7: In normal-power scan, `trigger_o` pulses for one cycle when `np_thresh_i` consecutive rounds have matched. Both channels' latest values are then copied to `trig_val_o`, and sampling continues without disturbing them.
- R8: A round that ends with `match_i` low clears the consecutive-match count. In normal-power scan it does not return the block to low-power scan.
- R9: The match count saturates at the threshold, so sustained matching after a trigger gives no further trigger.
- R10: In oneshot mode (`mode_i`=2), after power-up exactly one round is taken and `oneshot_done_o` pulses once whatever `match_i` is. Then `adc_pd_o` stays high, with no start and no trigger, until enable is toggled.
- R11: Clearing `enable_i` drives `adc_pd_o` high at the next edge, clears `np_active_o`, and stops all starts.
- R12: A one-cycle `soft_rst_i` returns the sequencer to idle and clears the match count and the promotion. If enable is still high, it restarts with a full power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Sequencer enable |
| soft_rst_i | input | 1 | Synchronous pulse that clears FSM and counters |
| mode_i | input | 2 | 0 low-power scan, 1 normal-power scan, 2 oneshot |
| pwrup_time_i | input | 8 | Power-up wait in cycles |
| wake_time_i | input | 32 | Low-power sleep interval in cycles |
| lp_thresh_i | input | 8 | Matching rounds needed to promote |
| np_thresh_i | input | 16 | Matching rounds needed to trigger |
| filter_en_i | input | 1 | At least one filter is enabled |
| match_i | input | 1 | Filter match for the round just finished |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_data_i | input | 10 | Conversion result |
| adc_pd_o | output | 1 | ADC power-down |
| adc_start_o | output | 1 | Conversion start strobe |
| adc_chn_sel_o | output | 1 | Channel being converted |
| np_active_o | output | 1 | Normal-power scan is active |
| trigger_o | output | 1 | Wakeup / interrupt trigger pulse |
| oneshot_done_o | output | 1 | Oneshot sample complete pulse |
| latest_o | output | 20 | Latest value per channel |
| trig_val_o | output | 20 | Values captured at the trigger |

## Verification
The hardest state to reach is a saturated normal-power count that must then be cleared by a single non-matching round and rebuilt. Reaching it means first promoting out of low-power scan, then holding the match flag for more rounds than the trigger threshold. The stimulus gets there by watching the channel-1 start strobe at the ports. Each match-flag change is applied right at that strobe, so it belongs to exactly one known round. The count of rounds before a second trigger then shows whether the count was cleared. The same round tracking, run across a soft reset, shows that a partial count does not survive it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_LP = 2'd0,
    MODE_NP = 2'd1,
    MODE_OS = 2'd2
  } scan_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PWRUP = 3'd1,
    S_START = 3'd2,
    S_WAIT  = 3'd3,
    S_EVAL  = 3'd4,
    S_SLEEP = 3'd5,
    S_HALT  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 8,
  parameter int TW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic           soft_rst_i,
  input  logic [1:0]     mode_i,
  input  logic [PW-1:0]  pwrup_time_i,
  input  logic [TW-1:0]  wake_time_i,
  input  logic           promote_i,
  input  logic           adc_valid_i,
  output logic           adc_pd_o,
  output logic           adc_start_o,
  output logic [CHW-1:0] chn_o,
  output logic           eval_o,
  output logic           np_o,
  output logic           os_done_o,
  output logic           store_en_o
);

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [TW-1:0]  tmr_q, tmr_d;
  logic           np_q, np_d;
  logic           is_os;

  assign is_os = (mode_i == MODE_OS);

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    np_d    = np_q;
    tmr_d   = TW'(tmr_q + TW'(1));
    unique case (state_q)
      S_IDLE: begin
        tmr_d = '0;
        ch_d  = '0;
        if (enable_i) begin
          state_d = S_PWRUP;
          np_d    = (mode_i == MODE_NP);
        end
      end
      S_PWRUP: begin
        if (tmr_q == TW'(pwrup_time_i)) begin
          state_d = S_START;
          tmr_d   = '0;
        end
      end
      S_START: begin
        tmr_d   = '0;
        state_d = S_WAIT;
      end
      S_WAIT: begin
        tmr_d = '0;
        if (adc_valid_i) begin
          if (ch_q == CHW'(NCH - 1)) begin
            state_d = S_EVAL;
          end else begin
            ch_d    = CHW'(ch_q + CHW'(1));
            state_d = S_START;
          end
        end
      end
      S_EVAL: begin
        tmr_d = '0;
        ch_d  = '0;
        if (is_os) begin
          state_d = S_HALT;
        end else if (np_q || promote_i) begin
          state_d = S_START;
          np_d    = 1'b1;
        end else begin
          state_d = S_SLEEP;
        end
      end
      S_SLEEP: begin
        if (tmr_q == wake_time_i) begin
          state_d = S_PWRUP;
          tmr_d   = '0;
        end
      end
      S_HALT: tmr_d = '0;
      default: begin
        state_d = S_IDLE;
        tmr_d   = '0;
      end
    endcase
    if (!enable_i || soft_rst_i) begin
      state_d = S_IDLE;
      np_d    = 1'b0;
      tmr_d   = '0;
      ch_d    = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      tmr_q   <= '0;
      np_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      tmr_q   <= tmr_d;
      np_q    <= np_d;
    end
  end

  assign adc_pd_o    = (state_q == S_IDLE) || (state_q == S_SLEEP) || (state_q == S_HALT);
  assign adc_start_o = (state_q == S_START);
  assign chn_o       = ch_q;
  assign eval_o      = (state_q == S_EVAL);
  assign np_o        = np_q;
  assign os_done_o   = eval_o && is_os;
  assign store_en_o  = (state_q == S_WAIT) && adc_valid_i;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o); // R3
  AST_START_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> !adc_pd_o); // R3
  AST_DISABLE_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (adc_pd_o && !np_o)); // R11
  AST_OS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HALT && enable_i && !soft_rst_i) |=> (adc_pd_o && !adc_start_o)); // R10
  AST_NP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (np_q && enable_i && !soft_rst_i) |=> np_q); // R8

endmodule

// File: rtl/adc_match_counter.sv
module adc_match_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          eval_i,
  input  logic          match_i,
  input  logic          restart_on_hit_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          below;

  assign below = (cnt_q < thr_i);
  assign hit_o = eval_i && match_i && below && (CW'(cnt_q + CW'(1)) == thr_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (eval_i) begin
      if (!match_i) begin
        cnt_d = '0;
      end else if (hit_o && restart_on_hit_i) begin
        cnt_d = '0;
      end else if (below) begin
        cnt_d = CW'(cnt_q + CW'(1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || eval_i) begin
      cnt_q <= cnt_d;
    end
  end

  AST_MISS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !match_i) |=> (cnt_q == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && match_i && !clr_i && (cnt_q >= thr_i)) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/adc_sample_store.sv
module adc_sample_store #(
  parameter int NCH = 2,
  parameter int DW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              cap_i,
  output logic [NCH*DW-1:0] latest_o,
  output logic [NCH*DW-1:0] trig_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] lat_q, trg_q;
    logic          lat_en;

    assign lat_en = wr_en_i && (wr_ch_i == CHW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_q <= '0;
      end else if (lat_en) begin
        lat_q <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        trg_q <= '0;
      end else if (cap_i) begin
        trg_q <= lat_q;
      end
    end

    assign latest_o[g*DW +: DW] = lat_q;
    assign trig_o[g*DW +: DW]   = trg_q;
  end

  AST_TRIG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (trig_o == $past(latest_o))); // R7
  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(trig_o)); // R7

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 10,
  parameter int PW  = 8,
  parameter int TW  = 32,
  parameter int LPW = 8,
  parameter int NPW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              soft_rst_i,
  input  logic [1:0]        mode_i,
  input  logic [PW-1:0]     pwrup_time_i,
  input  logic [TW-1:0]     wake_time_i,
  input  logic [LPW-1:0]    lp_thresh_i,
  input  logic [NPW-1:0]    np_thresh_i,
  input  logic              filter_en_i,
  input  logic              match_i,
  input  logic              adc_valid_i,
  input  logic [DW-1:0]     adc_data_i,
  output logic              adc_pd_o,
  output logic              adc_start_o,
  output logic [CHW-1:0]    adc_chn_sel_o,
  output logic              np_active_o,
  output logic              trigger_o,
  output logic              oneshot_done_o,
  output logic [NCH*DW-1:0] latest_o,
  output logic [NCH*DW-1:0] trig_val_o
);

  logic           eval, np, hit, promote, store_en, scan_eval, cnt_clr, eff_match;
  logic [CHW-1:0] chn;
  logic [NPW-1:0] thr;

  assign scan_eval = eval && (mode_i != MODE_OS);
  assign eff_match = match_i && filter_en_i;
  assign thr       = np ? np_thresh_i : NPW'(lp_thresh_i);
  assign cnt_clr   = soft_rst_i || !enable_i;
  assign promote   = hit && !np;
  assign trigger_o = hit && np;

  adc_seq_fsm #(.NCH(NCH), .PW(PW), .TW(TW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .soft_rst_i   (soft_rst_i),
    .mode_i       (mode_i),
    .pwrup_time_i (pwrup_time_i),
    .wake_time_i  (wake_time_i),
    .promote_i    (promote),
    .adc_valid_i  (adc_valid_i),
    .adc_pd_o     (adc_pd_o),
    .adc_start_o  (adc_start_o),
    .chn_o        (chn),
    .eval_o       (eval),
    .np_o         (np),
    .os_done_o    (oneshot_done_o),
    .store_en_o   (store_en)
  );

  adc_match_counter #(.CW(NPW)) u_cnt (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .clr_i            (cnt_clr),
    .eval_i           (scan_eval),
    .match_i          (eff_match),
    .restart_on_hit_i (!np),
    .thr_i            (thr),
    .hit_o            (hit)
  );

  adc_sample_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (store_en),
    .wr_ch_i   (chn),
    .wr_data_i (adc_data_i),
    .cap_i     (trigger_o),
    .latest_o  (latest_o),
    .trig_o    (trig_val_o)
  );

  assign adc_chn_sel_o = chn;
  assign np_active_o   = np;

endmodule

// File: tb/adc_scan_sequencer_tb.sv
module adc_scan_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, soft_rst, filter_en, match, adc_valid;
  logic [1:0]  mode;
  logic [7:0]  pwrup_time, lp_thresh;
  logic [31:0] wake_time;
  logic [15:0] np_thresh;
  logic [9:0]  adc_data, d0, d1;
  logic        adc_pd, adc_start, np_active, trigger, os_done;
  logic [0:0]  adc_chn_sel;
  logic [19:0] latest, trig_val;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_trig = 0, n_done = 0;

  always #2 clk = ~clk;

  adc_scan_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .soft_rst_i(soft_rst),
    .mode_i(mode), .pwrup_time_i(pwrup_time), .wake_time_i(wake_time),
    .lp_thresh_i(lp_thresh), .np_thresh_i(np_thresh), .filter_en_i(filter_en),
    .match_i(match), .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .adc_pd_o(adc_pd), .adc_start_o(adc_start), .adc_chn_sel_o(adc_chn_sel),
    .np_active_o(np_active), .trigger_o(trigger), .oneshot_done_o(os_done),
    .latest_o(latest), .trig_val_o(trig_val)
  );

  // ADC model: result returned three cycles after the start strobe
  logic [1:0] lat_cnt;
  logic       sel_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= 0; adc_valid <= 0; adc_data <= 0; sel_q <= 0;
    end else begin
      adc_valid <= 1'b0;
      if (adc_start) begin
        lat_cnt <= 2'd3;
        sel_q   <= adc_chn_sel[0];
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 2'd1;
        if (lat_cnt == 2'd1) begin
          adc_valid <= 1'b1;
          adc_data  <= sel_q ? d1 : d0;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (adc_start) n_start++;
      if (trigger)   n_trig++;
      if (os_done)   n_done++;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ch1();
    do @(negedge clk); while (!(adc_start && adc_chn_sel == 1'b1));
  endtask

  task automatic measure_pwrup(output int cnt, output int first_ch);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (adc_start) break;
      if (!adc_pd) cnt++;
    end
    first_ch = int'(adc_chn_sel);
  endtask

  localparam logic [20:0] OS_VEC [6] = '{
    {10'h000, 10'h3FF, 1'b0},
    {10'h3FF, 10'h000, 1'b1},
    {10'h155, 10'h2AA, 1'b1},
    {10'h2AA, 10'h155, 1'b0},
    {10'h001, 10'h200, 1'b1},
    {10'h3FE, 10'h07F, 1'b0}
  };

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt, ch, rounds, t0, s0, dn0;
    rst_n = 0; enable = 0; soft_rst = 0; filter_en = 0; match = 0; mode = 2'd0;
    pwrup_time = 8'd5; wake_time = 32'd10; lp_thresh = 8'd3; np_thresh = 16'd4;
    d0 = 10'h123; d1 = 10'h321;
    repeat (3) @(negedge clk);
    check_eq("R1", "pd in reset", int'(adc_pd), 1);
    rst_n = 1;
    @(negedge clk);
    check_eq("R1", "pd", int'(adc_pd), 1);
    check_eq("R1", "start", int'(adc_start), 0);
    check_eq("R1", "np", int'(np_active), 0);
    check_eq("R1", "trigger/done", int'(trigger) + int'(os_done), 0);
    check_eq("R1", "latest", int'(latest), 0);

    // R2/R3/R4: low-power scan, no match
    filter_en = 1; enable = 1;
    measure_pwrup(cnt, ch);
    check_eq("R2", "powered cycles before start", cnt, 6);
    check_eq("R3", "first channel", ch, 0);
    wait_ch1();
    check_eq("R3", "second start pd", int'(adc_pd), 0);
    do @(negedge clk); while (!adc_pd);
    check_eq("R3", "latest ch0", int'(latest[9:0]), 'h123);
    check_eq("R3", "latest ch1", int'(latest[19:10]), 'h321);
    cnt = 1;
    forever begin
      @(negedge clk);
      if (!adc_pd) break;
      cnt++;
    end
    check_eq("R4", "sleep cycles", cnt, 11);
    check_eq("R4", "no promotion", int'(np_active), 0);

    // R5: promotion after three matching rounds
    match = 1; rounds = 0;
    forever begin
      @(negedge clk);
      if (adc_start && adc_chn_sel == 1'b1) rounds++;
      if (np_active) break;
    end
    check_eq("R5", "matching rounds to promote", rounds, 3);
    check_eq("R5", "pd after promote", int'(adc_pd), 0);

    // R6/R7: normal-power trigger after four matching rounds
    d0 = 10'h155; d1 = 10'h2AA; t0 = n_trig; rounds = 0; cnt = 0;
    while (n_trig == t0) begin
      @(negedge clk);
      if (adc_pd) cnt++;
      if (adc_start && adc_chn_sel == 1'b1) rounds++;
    end
    check_eq("R6", "pd high cycles in NP", cnt, 0);
    check_eq("R7", "rounds to trigger", rounds, 4);
    check_eq("R7", "trig ch0", int'(trig_val[9:0]), 'h155);
    check_eq("R7", "trig ch1", int'(trig_val[19:10]), 'h2AA);

    // R9: saturation, sampling continues
    d0 = 10'h0F0;
    repeat (5) wait_ch1();
    repeat (6) @(negedge clk);
    check_eq("R9", "single trigger", n_trig, t0 + 1);
    check_eq("R7", "latest keeps updating", int'(latest[9:0]), 'h0F0);
    check_eq("R7", "trig value held", int'(trig_val[9:0]), 'h155);

    // R8: one missed round clears the count, stays in NP
    t0 = n_trig;
    wait_ch1(); match = 0;
    wait_ch1(); match = 1;
    wait_ch1(); wait_ch1();
    repeat (6) @(negedge clk);
    check_eq("R8", "no trigger after 3 rounds", n_trig, t0);
    check_eq("R8", "still NP", int'(np_active), 1);
    wait_ch1();
    repeat (6) @(negedge clk);
    check_eq("R8", "trigger after 4th round", n_trig, t0 + 1);

    // R11: disable
    enable = 0;
    @(negedge clk);
    check_eq("R11", "pd after disable", int'(adc_pd), 1);
    check_eq("R11", "np cleared", int'(np_active), 0);
    s0 = n_start;
    repeat (20) @(negedge clk);
    check_eq("R11", "no starts", n_start, s0);

    // R12: soft reset clears partial count and restarts
    mode = 2'd1; enable = 1;
    wait_ch1(); wait_ch1();
    repeat (6) @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    check_eq("R12", "pd after soft reset", int'(adc_pd), 1);
    check_eq("R12", "np after soft reset", int'(np_active), 0);
    measure_pwrup(cnt, ch);
    check_eq("R12", "restart power-up", cnt, 6);
    t0 = n_trig; rounds = 0;
    while (n_trig == t0) begin
      @(negedge clk);
      if (adc_start && adc_chn_sel == 1'b1) rounds++;
    end
    check_eq("R12", "rounds to trigger after reset", rounds, 4);

    // R5: no filter enabled, never promotes
    enable = 0;
    repeat (2) @(negedge clk);
    mode = 2'd0; filter_en = 0; wake_time = 32'd4; enable = 1;
    repeat (6) wait_ch1();
    repeat (6) @(negedge clk);
    check_eq("R5", "no promotion without filter", int'(np_active), 0);
    enable = 0;
    repeat (2) @(negedge clk);

    // R10: oneshot table
    mode = 2'd2; filter_en = 1;
    for (int i = 0; i < 6; i++) begin
      d0 = OS_VEC[i][20:11]; d1 = OS_VEC[i][10:1]; match = OS_VEC[i][0];
      s0 = n_start; t0 = n_trig; dn0 = n_done;
      enable = 1;
      do @(negedge clk); while (!os_done);
      check_eq("R10", "oneshot ch0", int'(latest[9:0]), int'(OS_VEC[i][20:11]));
      check_eq("R10", "oneshot ch1", int'(latest[19:10]), int'(OS_VEC[i][10:1]));
      repeat (20) @(negedge clk);
      check_eq("R10", "starts per oneshot", n_start - s0, 2);
      check_eq("R10", "done pulses", n_done - dn0, 1);
      check_eq("R10", "pd after oneshot", int'(adc_pd), 1);
      check_eq("R10", "no trigger in oneshot", n_trig, t0);
      enable = 0;
      repeat (2) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule